// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps time of day in four packed-BCD byte registers: hundredths of a second, seconds, minutes and hours. A single-cycle tick input, one per hundredth of a second, advances the chain. Each register rolls over at its own top value and passes a carry to the next register. The hours byte holds its own mode bit. With that bit clear the hours count in 24-hour form. With it set they count in 12-hour form and bit 5 holds the PM flag. When the hours wrap past the end of a day, the block sends a one-cycle day pulse to a downstream calendar.

Software reaches the registers through a plain synchronous port: an address, write data, a write enable and registered read data. Every write stores the data ANDed with the bits that register implements. Bit 7 of the seconds byte is a halt flag that stops all counting. Out-of-range values that get written do not lock the chain up. Their later behaviour is fixed: the register steps digit by digit and rolls over only when it matches its top value exactly.

Top module: `bcd_tod_chain`

## Requirements
- R1: The hundredths register (address 0) counts 00h..99h in BCD. A tick at 99h gives 00h and advances seconds.
- R2: Seconds (address 1, bits 6:0) and minutes (address 2) each count 00h..59h. A carry into either one at 59h gives 00h and passes the carry on.
- R3: With hours (address 3) bit 6 clear, a carry steps the hours 00h..23h. A carry at 23h gives 00h, and dayCarry is high for exactly the one cycle that follows that clock edge.
- R4: With hours bit 6 set, the hours step 52h, 41h..49h, 50h, 51h, 72h, 61h..69h, 70h, 71h. Bit 5 is PM. From 71h the next step is 52h and it produces the dayCarry pulse.
- R5: A write stores the data ANDed with a mask. The masks are FFh for hundredths and seconds and 7Fh for minutes and hours. At most one register is written per cycle.
- R6: While seconds bit 7 is 1, ticks change no register and produce no dayCarry.
- R7: A stored value below the top value counts on from where it is, with a low digit of 9 or more giving 0 and a carry into the high digit. Examples: 0Ah gives 10h, and a minutes value of 3Bh gives 40h.
- R8: A stored value above the top value never carries out. It keeps stepping digit by digit and wraps through 00h inside the register's counting bits (seconds 7Ah gives 00h, 24-hour hours 39h gives 00h). The next register and dayCarry stay unchanged.
- R9: A write in the same cycle as a tick wins for the written register, and that register's increment is lost.
- R10: After reset every register reads 00h (24-hour mode, not halted) and dayCarry is 0.
- R11: rdData shows, one clock after addr is presented, the value of the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle hundredth-of-a-second advance strobe |
| addr | input | ADDR_W | Register select: 0 hundredths, 1 seconds, 2 minutes, 3 hours |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| dayCarry | output | 1 | One-cycle pulse when the hours wrap to a new day |

## Verification
The 24-hour and 12-hour hour sequences are swept in full. Before each single tick the lower three registers are preloaded to their top values, so every hour step, every AM/PM change and the exact day-pulse position are each checked in isolation. Separate sweeps over every seconds value and over a full minute of raw ticks tell a wrong carry threshold apart from a wrong BCD digit step. Directed loads of masked, below-top and above-top values separate the masking logic from the digit-step logic and from the rollover compare. Halt and same-cycle write-plus-tick patterns show whether the write path takes priority over counting.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NREG   = 4;
  localparam int DATA_W = 8;

  localparam int IDX_HUND = 0;
  localparam int IDX_SEC  = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_HOUR = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic [NREG-1:0] wr;
    logic [NREG-1:0] adv;
  } todStrobe_t;

  // per-digit BCD step; only bits inside cntMask change
  function automatic logic [DATA_W-1:0] bcdStep(input logic [DATA_W-1:0] v,
                                                input logic [DATA_W-1:0] cntMask);
    logic [3:0] lo;
    logic [3:0] hi;
    lo = v[3:0];
    hi = v[7:4];
    if (lo >= 4'd9) begin
      lo = 4'd0;
      hi = (hi >= 4'd9) ? 4'd0 : hi + 4'd1;
    end else begin
      lo = lo + 4'd1;
    end
    return ({hi, lo} & cntMask) | (v & ~cntMask);
  endfunction
endpackage

// File: rtl/tod_control.sv
module tod_control
  import tod_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic            halted,
  input  logic [NREG-1:0] atMax,
  output todStrobe_t      str,
  output logic            dayCarry
);
  logic [NREG-1:0] advChain;
  logic [NREG-1:0] wrDec;

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_strobe
      assign wrDec[i] = wrEn && (addr == ADDR_W'(i));
      if (i == 0) begin : g_head
        assign advChain[i] = tick && !halted;
      end else begin : g_link
        assign advChain[i] = advChain[i-1] && atMax[i-1];
      end
    end
  endgenerate

  assign str.wr  = wrDec;
  assign str.adv = advChain;

  always_ff @(posedge clk) begin
    if (!rstN) dayCarry <= 1'b0;
    else       dayCarry <= advChain[IDX_HOUR] && atMax[IDX_HOUR];
  end

  // R6
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (str.adv == '0));

  // R5
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(str.wr));
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [DATA_W-1:0] HUND_WMASK = 8'hFF,
  parameter logic [DATA_W-1:0] SEC_WMASK  = 8'hFF,
  parameter logic [DATA_W-1:0] MIN_WMASK  = 8'h7F,
  parameter logic [DATA_W-1:0] HOUR_WMASK = 8'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  todStrobe_t        str,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [NREG-1:0]   atMax,
  output logic              halted,
  output logic [DATA_W-1:0] hourQ
);
  localparam logic [NREG-1:0][DATA_W-1:0] WMASK =
    {HOUR_WMASK, MIN_WMASK, SEC_WMASK, HUND_WMASK};
  localparam logic [DATA_W-1:0] TOP_HUND = 8'h99;
  localparam logic [DATA_W-1:0] TOP_SIX  = 8'h59;
  localparam logic [DATA_W-1:0] TOP_H24  = 8'h23;
  localparam logic [DATA_W-1:0] TOP_H12  = 8'h71;
  localparam logic [DATA_W-1:0] NOON_AM  = 8'h51;
  localparam int MODE_BIT = 6;

  logic [NREG-1:0][DATA_W-1:0] regQ;
  logic [NREG-1:0][DATA_W-1:0] nextVal;
  logic mode12;

  assign mode12 = regQ[IDX_HOUR][MODE_BIT];
  assign halted = regQ[IDX_SEC][7];
  assign hourQ  = regQ[IDX_HOUR];

  always_comb begin
    atMax[IDX_HUND] = (regQ[IDX_HUND] == TOP_HUND);
    atMax[IDX_SEC]  = (regQ[IDX_SEC]  == TOP_SIX);
    atMax[IDX_MIN]  = (regQ[IDX_MIN]  == TOP_SIX);
    atMax[IDX_HOUR] = mode12 ? (regQ[IDX_HOUR] == TOP_H12)
                             : (regQ[IDX_HOUR] == TOP_H24);
  end

  always_comb begin
    nextVal[IDX_HUND] = atMax[IDX_HUND] ? 8'h00 : bcdStep(regQ[IDX_HUND], 8'hFF);
    nextVal[IDX_SEC]  = atMax[IDX_SEC]  ? 8'h00 : bcdStep(regQ[IDX_SEC], 8'h7F);
    nextVal[IDX_MIN]  = atMax[IDX_MIN]  ? 8'h00 : bcdStep(regQ[IDX_MIN], 8'h7F);
    if (!mode12) begin
      nextVal[IDX_HOUR] = atMax[IDX_HOUR] ? 8'h00 : bcdStep(regQ[IDX_HOUR], 8'h3F);
    end else if (atMax[IDX_HOUR]) begin
      nextVal[IDX_HOUR] = 8'h52;
    end else if (regQ[IDX_HOUR] == NOON_AM) begin
      nextVal[IDX_HOUR] = 8'h72;
    end else if (regQ[IDX_HOUR][4:0] == 5'h12) begin
      nextVal[IDX_HOUR] = {regQ[IDX_HOUR][7:5], 5'h01};
    end else begin
      nextVal[IDX_HOUR] = bcdStep(regQ[IDX_HOUR], 8'h1F);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (str.wr[r])       regQ[r] <= wrData & WMASK[r];
        else if (str.adv[r]) regQ[r] <= nextVal[r];
      end
    end
  end

  logic inRange;
  assign inRange = ((rdAddr >> 2) == '0);

  always_ff @(posedge clk) begin
    if (!rstN)        rdData <= '0;
    else if (inRange) rdData <= regQ[rdAddr[1:0]];
    else              rdData <= '0;
  end

  // R9
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_wrchk
      wr_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
        str.wr[g] |=> (regQ[g] == ($past(wrData) & WMASK[g])));
    end
  endgenerate

  // R1
  hund_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!str.wr[IDX_HUND] && str.adv[IDX_HUND] && regQ[IDX_HUND] == TOP_HUND)
      |=> (regQ[IDX_HUND] == 8'h00));

  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!str.wr[IDX_SEC] && !str.adv[IDX_SEC]) |=> $stable(regQ[IDX_SEC]));
endmodule

// File: rtl/bcd_tod_chain.sv
module bcd_tod_chain
  import tod_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              dayCarry
);
  todStrobe_t      str;
  logic [NREG-1:0] atMax;
  logic            halted;
  logic [DATA_W-1:0] hourQ;

  tod_control #(.ADDR_W(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .halted(halted), .atMax(atMax), .str(str), .dayCarry(dayCarry)
  );

  tod_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .str(str), .wrData(wrData), .rdAddr(addr),
    .rdData(rdData), .atMax(atMax), .halted(halted), .hourQ(hourQ)
  );

  // R3
  day_hour_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dayCarry && !$past(str.wr[IDX_HOUR])) |-> (hourQ == 8'h00 || hourQ == 8'h52));
endmodule

// File: tb/bcd_tod_chain_bench.sv
module bcd_tod_chain_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       dayCarry;
  logic       dayObs;
  logic       done = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bcd_tod_chain u_bcd_tod_chain (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .dayCarry(dayCarry)
  );

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [7:0] h12(input int k);
    int hr;
    hr = (k % 12 == 0) ? 12 : k % 12;
    return 8'h40 | ((k >= 12) ? 8'h20 : 8'h00) | bcd(hr);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    dayObs = dayCarry;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    @(negedge clk);
    v = rdData;
  endtask

  task automatic setTime(input logic [7:0] h, input logic [7:0] m,
                         input logic [7:0] s, input logic [7:0] c);
    wr(2'd1, s); wr(2'd2, m); wr(2'd3, h); wr(2'd0, c);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    chk("R10 dayCarry", {7'd0, dayCarry}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R10 reg", v, 8'h00);
    end

    // R1 / R11 hundredths sweep, then one full minute of ticks
    for (int n = 1; n <= 100; n++) begin
      doTick(); rd(2'd0, v); chk("R1 hund", v, bcd(n % 100));
    end
    rd(2'd1, v); chk("R1 carry sec", v, 8'h01);
    for (int n = 0; n < 5900; n++) doTick();
    rd(2'd0, v); chk("R2 hund", v, 8'h00);
    rd(2'd1, v); chk("R2 sec", v, 8'h00);
    rd(2'd2, v); chk("R2 min", v, 8'h01);

    // R2 seconds sweep
    for (int s = 0; s < 60; s++) begin
      setTime(8'h00, 8'h00, bcd(s), 8'h99);
      doTick();
      rd(2'd1, v); chk("R2 sec step", v, bcd((s + 1) % 60));
      rd(2'd2, v); chk("R2 min carry", v, (s == 59) ? 8'h01 : 8'h00);
    end

    // R3 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      setTime(bcd(h), 8'h59, 8'h59, 8'h99);
      doTick();
      chk("R3 day", {7'd0, dayObs}, (h == 23) ? 8'h01 : 8'h00);
      rd(2'd3, v); chk("R3 hour", v, bcd((h + 1) % 24));
      chk("R3 pulse width", {7'd0, dayCarry}, 8'h00);
      rd(2'd2, v); chk("R2 min wrap", v, 8'h00);
    end

    // R4 12-hour sweep
    for (int k = 0; k < 24; k++) begin
      setTime(h12(k), 8'h59, 8'h59, 8'h99);
      doTick();
      chk("R4 day", {7'd0, dayObs}, (k == 23) ? 8'h01 : 8'h00);
      rd(2'd3, v); chk("R4 hour", v, h12((k + 1) % 24));
    end

    // R5 write masks
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R5 hund mask", v, 8'hFF);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R5 min mask", v, 8'h7F);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R5 hour mask", v, 8'h7F);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R5 sec mask", v, 8'hFF);

    // R6 halt
    setTime(8'h23, 8'h59, 8'h92, 8'h99);
    repeat (5) begin
      doTick(); chk("R6 no day", {7'd0, dayObs}, 8'h00);
    end
    rd(2'd0, v); chk("R6 hund frozen", v, 8'h99);
    rd(2'd1, v); chk("R6 sec frozen", v, 8'h92);
    rd(2'd3, v); chk("R6 hour frozen", v, 8'h23);

    // R7 illegal below top
    setTime(8'h00, 8'h3B, 8'h59, 8'h99);
    doTick(); rd(2'd2, v); chk("R7 min 3B", v, 8'h40);
    setTime(8'h00, 8'h00, 8'h00, 8'h0A);
    doTick(); rd(2'd0, v); chk("R7 hund 0A", v, 8'h10);

    // R8 illegal above top
    setTime(8'h00, 8'h10, 8'h7A, 8'h99);
    doTick();
    rd(2'd1, v); chk("R8 sec 7A", v, 8'h00);
    rd(2'd2, v); chk("R8 min untouched", v, 8'h10);
    setTime(8'h38, 8'h59, 8'h59, 8'h99);
    doTick(); rd(2'd3, v); chk("R8 hour 38", v, 8'h39);
    setTime(8'h39, 8'h59, 8'h59, 8'h99);
    doTick();
    chk("R8 no day", {7'd0, dayObs}, 8'h00);
    rd(2'd3, v); chk("R8 hour 39", v, 8'h00);

    // R9 write beats tick
    setTime(8'h00, 8'h00, 8'h05, 8'h20);
    addr = 2'd0; wrData = 8'h45; wrEn = 1'b1; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    rd(2'd0, v); chk("R9 hund", v, 8'h45);
    rd(2'd1, v); chk("R9 sec", v, 8'h05);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule